// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that walks a chain of descriptors stored in memory. Each descriptor is four 32-bit words. Software writes the address of the first descriptor and sets the run bit. The channel then fetches the descriptor and copies the programmed number of bytes from the source address to the target address. Each address either advances or stays fixed, as the command word says. The channel then follows the link word to the next descriptor, or halts if the link carries the stop flag. A link that points back to an earlier descriptor forms a ring, and the ring repeats until software clears run.

Data moves one item at a time. An item is a read of up to four bytes followed by a write of the same bytes. Items are grouped into bursts. When flow control is selected, each burst waits for the peripheral request line to be high. Completion, start and bus-error events set sticky flags, and the interrupt output is high while any flag is set. Software can read the current source and target addresses at any time to work out how many bytes remain.

Top module: `chain_dma`

## Requirements
- R1: After reset the channel is stopped, run is 0, all flags are 0 and `irq` is low. The control register (reg_addr 0) reads 0x00000008. Its layout is: bit 31 run, bit 8 request pending, bit 3 stopped, bit 2 end flag, bit 1 start flag, bit 0 bus-error flag.
- R2: A descriptor is fetched as four words at pointer+0, +4, +8 and +12, in this order: link, source, target, command. The fetch address ignores bits 3:0 of the pointer written at reg_addr 1.
- R3: When command bits 31 (source increment) and 30 (target increment) are both set, the target receives an exact copy of the byte-length source bytes. Bytes beyond the target range are not changed.
- R4: When bit 31 is clear, every item reads from the same source address. When bit 30 is clear, every item writes to the same target address. A held address register keeps its start value.
- R5: The item size is the smallest of three values: the width, the bytes left in the descriptor and the bytes left in the burst. Width is coded in command bits 15:14 (1 = 1 byte, 2 = 2 bytes, 3 or 0 = 4 bytes). Burst size is coded in bits 17:16 (1 or 0 = 8 bytes, 2 = 16 bytes, 3 = 32 bytes). The byte length is in bits 12:0.
- R6: When command bit 29 or bit 28 is set, each burst starts only when `dreq` is high, and the last burst is cut to the bytes remaining. Control bit 8 reflects `dreq`.
- R7: After a descriptor completes, a link with bit 0 clear fetches the next descriptor at link bits 31:4. A link with bit 0 set clears run and sets the stopped bit once the final write has been acknowledged.
- R8: Command bit 22 sets the start flag when the descriptor is fetched. Command bit 21 sets the end flag when the descriptor completes. `irq` is the OR of the three flags. Writing 1 to a flag bit clears it.
- R9: An error response on any memory access sets the bus-error flag, clears run and stops the channel.
- R10: Clearing run stops the channel at the next item boundary. A circular chain keeps running until run is cleared.
- R11: reg_addr 2 and reg_addr 3 read the address of the next source item and the next target item.
- R12: A descriptor with length 0 moves no data, and the chain continues past it.
- R13: A memory request keeps its address and direction stable until it is acknowledged or rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 descriptor pointer, 2 source, 3 target |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_bytes | output | 3 | Number of bytes in the access, 1 to 4 |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access rejected with an error |
| dreq | input | 1 | Peripheral request used for flow-controlled bursts |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The copy function is tried with random chains of one to three descriptors. These chains mix widths, burst codes, lengths and held addresses, and they separate item sizing errors from link-following errors. Directed cases isolate specific behaviour:
- a fill from a held source and a write to a held target, which show whether items are split at the right sizes;
- a 13-byte flow-controlled transfer stepped one request at a time, which shows the burst length and the shortened last burst;
- a zero-length link, an error source address, a start-only interrupt and a ring stopped by software.

A memory model with a random response delay checks that every stalled request stays stable.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int LEN_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [2:0]  mem_bytes,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic        dreq,
  output logic        irq
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ARM, S_RD, S_WR, S_DONE} st_t;

  st_t              st_q;
  logic             run_q, inc_s_q, inc_t_q, flow_q, eirq_q;
  logic [2:0]       flg_q;
  logic [1:0]       widx_q, wcode_q, bcode_q;
  logic [31:0]      dptr_q, link_q, src_q, tgt_q, data_q;
  logic [LEN_W-1:0] len_q;
  logic [5:0]       bcnt_q, blen;
  logic [2:0]       wbytes, item;

  always_comb begin
    case (wcode_q)
      2'd1:    wbytes = 3'd1;
      2'd2:    wbytes = 3'd2;
      default: wbytes = 3'd4;
    endcase
    case (bcode_q)
      2'd2:    blen = 6'd16;
      2'd3:    blen = 6'd32;
      default: blen = 6'd8;
    endcase
    item = wbytes;
    if (len_q < LEN_W'(item)) item = len_q[2:0];
    if (bcnt_q < 6'(item)) item = bcnt_q[2:0];
  end

  assign mem_req   = (st_q == S_FETCH) || (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = (st_q == S_WR);
  assign mem_bytes = (st_q == S_FETCH) ? 3'd4 : item;
  assign mem_wdata = data_q;
  assign mem_addr  = (st_q == S_FETCH) ? {dptr_q[31:4], widx_q, 2'b00} :
                     (st_q == S_RD)    ? src_q : tgt_q;
  assign irq       = |flg_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {run_q, 22'd0, dreq, 4'd0, st_q == S_IDLE, flg_q};
      2'd1:    reg_rdata = dptr_q;
      2'd2:    reg_rdata = src_q;
      default: reg_rdata = tgt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;   run_q <= 1'b0;   flg_q <= '0;
      widx_q <= '0;     wcode_q <= '0;   bcode_q <= '0;
      inc_s_q <= 1'b0;  inc_t_q <= 1'b0; flow_q <= 1'b0; eirq_q <= 1'b0;
      dptr_q <= '0;     link_q <= '0;    src_q <= '0;   tgt_q <= '0;
      data_q <= '0;     len_q <= '0;     bcnt_q <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) begin
        run_q <= reg_wdata[31];
        flg_q <= flg_q & ~reg_wdata[2:0];
        if (reg_wdata[31] && st_q == S_IDLE) begin
          st_q   <= S_FETCH;
          widx_q <= '0;
        end
      end
      if (reg_wr && reg_addr == 2'd1 && st_q == S_IDLE) dptr_q <= reg_wdata;

      if (mem_req && mem_err) begin
        flg_q[0] <= 1'b1;
        run_q    <= 1'b0;
        st_q     <= S_IDLE;
      end else begin
        case (st_q)
          S_FETCH: if (mem_ack) begin
            widx_q <= widx_q + 2'd1;
            case (widx_q)
              2'd0: link_q <= mem_rdata;
              2'd1: src_q  <= mem_rdata;
              2'd2: tgt_q  <= mem_rdata;
              default: begin
                inc_s_q <= mem_rdata[31];
                inc_t_q <= mem_rdata[30];
                flow_q  <= mem_rdata[29] | mem_rdata[28];
                eirq_q  <= mem_rdata[21];
                bcode_q <= mem_rdata[17:16];
                wcode_q <= mem_rdata[15:14];
                len_q   <= mem_rdata[LEN_W-1:0];
                bcnt_q  <= '0;
                if (mem_rdata[22]) flg_q[1] <= 1'b1;
                st_q    <= S_ARM;
              end
            endcase
          end
          S_ARM: begin
            if (!run_q)                st_q <= S_IDLE;
            else if (len_q == '0)      st_q <= S_DONE;
            else if (bcnt_q != '0)     st_q <= S_RD;
            else if (!flow_q || dreq) begin
              bcnt_q <= blen;
              st_q   <= S_RD;
            end
          end
          S_RD: if (mem_ack) begin
            data_q <= mem_rdata;
            st_q   <= S_WR;
          end
          S_WR: if (mem_ack) begin
            if (inc_s_q) src_q <= src_q + 32'(item);
            if (inc_t_q) tgt_q <= tgt_q + 32'(item);
            len_q  <= len_q - LEN_W'(item);
            bcnt_q <= bcnt_q - 6'(item);
            st_q   <= S_ARM;
          end
          S_DONE: begin
            if (eirq_q) flg_q[2] <= 1'b1;
            if (link_q[0]) run_q <= 1'b0;
            if (link_q[0] || !run_q) st_q <= S_IDLE;
            else begin
              dptr_q <= link_q;
              widx_q <= '0;
              st_q   <= S_FETCH;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_req_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_err_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_err |=> st_q == S_IDLE && !run_q && flg_q[0]);

  assert_len_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && !mem_err |=> len_q == $past(len_q) - LEN_W'($past(mem_bytes)));

  assert_stop_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_DONE && link_q[0] |=> st_q == S_IDLE && !run_q);

  assert_flow_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_ARM && run_q && len_q != '0 && bcnt_q == '0 && flow_q && !dreq |=> !mem_req);
endmodule

// File: tb/tb_chain_dma.sv
`timescale 1ns/1ps
module tb_chain_dma;
  logic        clk = 1'b0;
  logic        rst_n, reg_wr, dreq, mem_req, mem_we, mem_ack, mem_err, irq;
  logic [1:0]  reg_addr;
  logic [2:0]  mem_bytes;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  mem   [0:4095];
  logic [7:0]  exp_m [0:4095];
  logic [31:0] exp_src, exp_tgt;
  int checks = 0, fails = 0, stall_bad = 0;

  always #2.5 clk = ~clk;

  chain_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .dreq(dreq), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, expv);
    end
  endtask

  initial begin
    int dly = 0;
    logic stalled = 1'b0;
    logic [31:0] s_addr = '0;
    logic s_we = 1'b0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (stalled && mem_req && (mem_addr !== s_addr || mem_we !== s_we)) stall_bad++;
      stalled = 1'b0;
      mem_ack = 1'b0; mem_err = 1'b0;
      if (mem_req && rst_n) begin
        if (dly > 0) begin
          dly--;
          stalled = 1'b1; s_addr = mem_addr; s_we = mem_we;
        end else begin
          dly = int'($urandom % 3);
          if (mem_addr[31]) mem_err = 1'b1;
          else begin
            mem_ack = 1'b1;
            if (mem_we)
              for (int b = 0; b < int'(mem_bytes); b++) mem[12'(mem_addr + 32'(b))] = mem_wdata[8*b +: 8];
            else
              mem_rdata = {mem[12'(mem_addr + 32'd3)], mem[12'(mem_addr + 32'd2)],
                           mem[12'(mem_addr + 32'd1)], mem[12'(mem_addr)]};
          end
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, v);
      if (v[3]) break;
    end
  endtask

  task automatic run_from(input logic [31:0] p);
    wr(2'd1, p); wr(2'd0, 32'h8000_0000); wait_stop();
  endtask

  task automatic put_desc(input logic [11:0] a, input logic [31:0] lk, s, t, c);
    logic [127:0] w;
    w = {c, t, s, lk};
    for (int b = 0; b < 16; b++) begin
      mem[a + 12'(b)] = w[8*b +: 8];
      exp_m[a + 12'(b)] = w[8*b +: 8];
    end
  endtask

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return {exp_m[12'(a + 32'd3)], exp_m[12'(a + 32'd2)], exp_m[12'(a + 32'd1)], exp_m[12'(a)]};
  endfunction

  task automatic model(input logic [31:0] p);
    logic [31:0] dp, lk, s, t, c;
    logic [7:0] tmp [4];
    int len, w, bl, bc, n;
    dp = {p[31:4], 4'd0};
    for (int g = 0; g < 8; g++) begin
      lk = rdw(dp); s = rdw(dp + 4); t = rdw(dp + 8); c = rdw(dp + 12);
      len = int'(c[12:0]);
      w  = (c[15:14] == 2'd1) ? 1 : (c[15:14] == 2'd2) ? 2 : 4;
      bl = (c[17:16] == 2'd2) ? 16 : (c[17:16] == 2'd3) ? 32 : 8;
      bc = 0;
      while (len > 0) begin
        if (bc == 0) bc = bl;
        n = w;
        if (len < n) n = len;
        if (bc < n) n = bc;
        for (int b = 0; b < n; b++) tmp[b] = exp_m[12'(s + 32'(b))];
        for (int b = 0; b < n; b++) exp_m[12'(t + 32'(b))] = tmp[b];
        if (c[31]) s = s + 32'(n);
        if (c[30]) t = t + 32'(n);
        len -= n; bc -= n;
      end
      exp_src = s; exp_tgt = t;
      if (lk[0]) break;
      dp = {lk[31:4], 4'd0};
    end
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== exp_m[i]) bad++;
    chk(bad == 0, req, "memory bytes differing", 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    int k;
    void'($urandom(32'd77));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; dreq = 1'b0;
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'($urandom); exp_m[i] = mem[i]; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); chk(v == 32'h8, "R1", "control after reset", v, 32'h8);
    chk(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'd0);

    // R2 R3: plain copy; pointer low bits ignored
    put_desc(12'h040, 32'h1, 32'h100, 32'h800, 32'hC020_0000 | (1 << 16) | (3 << 14) | 13);
    model(32'h40); run_from(32'h4C);
    mem_cmp("R3");
    rd(2'd2, v); chk(v == 32'h10D, "R11", "source after copy", v, 32'h10D);
    rd(2'd3, v); chk(v == 32'h80D, "R2", "target after copy", v, 32'h80D);
    rd(2'd0, v); chk(v == 32'hC, "R7", "stopped with end flag", v, 32'hC);
    chk(irq == 1'b1, "R8", "irq with end flag", 32'(irq), 32'd1);
    wr(2'd0, 32'h4);
    rd(2'd0, v); chk(v == 32'h8, "R8", "end flag cleared by write", v, 32'h8);
    chk(irq == 1'b0, "R8", "irq after clear", 32'(irq), 32'd0);

    // R4: held source fill
    put_desc(12'h040, 32'h1, 32'h200, 32'h900, 32'h4000_0000 | (1 << 16) | (2 << 14) | 7);
    model(32'h40); run_from(32'h40);
    mem_cmp("R4");
    rd(2'd2, v); chk(v == 32'h200, "R4", "held source", v, 32'h200);
    rd(2'd3, v); chk(v == 32'h907, "R11", "target after fill", v, 32'h907);

    // R5: held target, item split 4,4,2
    put_desc(12'h040, 32'h1, 32'h300, 32'hA00, 32'h8000_0000 | (1 << 16) | (3 << 14) | 10);
    model(32'h40); run_from(32'h40);
    mem_cmp("R5");
    rd(2'd3, v); chk(v == 32'hA00, "R4", "held target", v, 32'hA00);

    // R6: flow control, 13 bytes in bursts of 8
    put_desc(12'h040, 32'h1, 32'h400, 32'hB00, 32'hD000_0000 | (1 << 16) | (3 << 14) | 13);
    model(32'h40);
    wr(2'd1, 32'h40); wr(2'd0, 32'h8000_0000);
    repeat (50) @(negedge clk);
    rd(2'd2, v); chk(v == 32'h400, "R6", "no burst without request", v, 32'h400);
    rd(2'd0, v); chk((v & 32'h108) == 0, "R6", "pending low, not stopped", v & 32'h108, 32'h0);
    @(negedge clk); dreq = 1'b1; reg_addr = 2'd0; #1 v = reg_rdata;
    chk(v[8] == 1'b1, "R6", "request pending bit", 32'(v[8]), 32'd1);
    @(negedge clk); dreq = 1'b0;
    repeat (40) @(negedge clk);
    rd(2'd2, v); chk(v == 32'h408, "R6", "one burst of 8 bytes", v, 32'h408);
    @(negedge clk); dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    wait_stop();
    rd(2'd2, v); chk(v == 32'h40D, "R6", "shortened last burst", v, 32'h40D);
    mem_cmp("R6");
    wr(2'd0, 32'h7);

    // R8: start interrupt only
    put_desc(12'h040, 32'h1, 32'h500, 32'hC00, 32'hC040_0000 | (1 << 16) | (3 << 14) | 4);
    model(32'h40); run_from(32'h40);
    rd(2'd0, v); chk(v == 32'hA, "R8", "start flag only", v, 32'hA);
    mem_cmp("R8");
    wr(2'd0, 32'h7);

    // R9: bus error on source read
    put_desc(12'h040, 32'h1, 32'h8000_0100, 32'hD00, 32'hC020_0000 | (1 << 16) | (3 << 14) | 8);
    run_from(32'h40);
    rd(2'd0, v); chk(v == 32'h9, "R9", "error stops channel", v, 32'h9);
    chk(irq == 1'b1, "R9", "irq on error", 32'(irq), 32'd1);
    mem_cmp("R9");
    wr(2'd0, 32'h7);

    // R12: zero-length descriptor chained to a normal one
    put_desc(12'h040, 32'h50, 32'h600, 32'hD00, 32'hC020_0000 | (1 << 16) | (3 << 14));
    put_desc(12'h050, 32'h1, 32'h610, 32'hD40, 32'hC020_0000 | (1 << 16) | (3 << 14) | 5);
    model(32'h40); run_from(32'h40);
    mem_cmp("R12");
    rd(2'd3, v); chk(v == 32'hD45, "R7", "link followed", v, 32'hD45);
    wr(2'd0, 32'h7);

    // R5 R7: random chains
    for (int it = 0; it < 6; it++) begin
      k = 1 + int'($urandom % 3);
      for (int i = 0; i < k; i++) begin
        c = '0;
        c[31] = ($urandom % 4) != 0;
        c[30] = ($urandom % 4) != 0;
        c[21] = 1'b1;
        c[17:16] = 2'(1 + $urandom % 3);
        c[15:14] = 2'(1 + $urandom % 3);
        c[12:0] = 13'(1 + $urandom % 96);
        put_desc(12'(i * 16), (i == k - 1) ? 32'h1 : 32'((i + 1) * 16),
                 32'h100 + ($urandom % 32'h500), 32'h800 + ($urandom % 32'h600), c);
      end
      model(32'h0); run_from(32'h0);
      mem_cmp("R5");
      rd(2'd2, v); chk(v == exp_src, "R11", "source after chain", v, exp_src);
      rd(2'd3, v); chk(v == exp_tgt, "R7", "target after chain", v, exp_tgt);
      wr(2'd0, 32'h7);
    end

    // R10: circular chain stopped by software
    put_desc(12'h080, 32'h90, 32'h700, 32'hE00, 32'hC020_0000 | (1 << 16) | (1 << 14) | 64);
    put_desc(12'h090, 32'h80, 32'h740, 32'hE40, 32'hC020_0000 | (1 << 16) | (1 << 14) | 64);
    model(32'h80);
    wr(2'd1, 32'h80); wr(2'd0, 32'h8000_0000);
    repeat (3000) @(negedge clk);
    rd(2'd0, v); chk((v & 32'h8000_000C) == 32'h8000_0004, "R10", "ring still running", v & 32'h8000_000C, 32'h8000_0004);
    wr(2'd0, 32'h0); wait_stop();
    rd(2'd0, v); chk((v & 32'h8000_0008) == 32'h8, "R10", "ring stopped by run clear", v & 32'h8000_0008, 32'h8);
    mem_cmp("R10");
    wr(2'd0, 32'h7);

    chk(stall_bad == 0, "R13", "request changed while stalled", 32'(stall_bad), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule